// File: doc/BRIEF.md
# Keyed-Restart Watchdog Timer

This block is a watchdog for a small controller. Software arms it by writing a fixed four-bit key, and in the same write it chooses which of two tick strobes drives the count. One strobe comes from a timebase on the fast main clock and the other from a prescaler on the slow subclock. After the watchdog is armed, software must write the same key again before the tick counter runs out. If it does not, the block emits a reset pulse.

The same key value does two jobs. The first matching write after reset arms the block, and every later matching write restarts the count. A small counter counts the selected ticks and fires on the second tick after the last start or restart. The time from a restart to the reset pulse is therefore between one and two tick periods, depending on where the restart falls within the current period.

Software has no way to stop an armed watchdog. The block returns to the unarmed state only through its reset input, or by itself after it has issued the reset pulse. The tick inputs are one-cycle enable strobes in the system clock domain.

Top module: `wdt_keyed`

## Requirements
- R1: While reset is applied, and afterwards until the block is armed, `wdt_rst` stays low and the block is unarmed.
- R2: While the block is unarmed, a write (`wr_en`=1) with `wr_key`=4'b0101 arms it, and the tick count starts from zero. A tick in that same cycle is not counted.
- R3: While the block is unarmed, a write with any other key value has no effect: later ticks on either strobe produce no reset.
- R4: `wr_src` in the arming write selects the tick strobe: 0 selects `tick_main` and 1 selects `tick_sub`. Strobes on the other input are not counted.
- R5: Once the block is armed, the value of `wr_src` in later writes is ignored. The source chosen at arming stays in force.
- R6: While the block is armed, a write with key 4'b0101 restarts the tick count from zero. This includes a cycle that also carries a selected tick, where the restart wins and no reset is issued.
- R7: While the block is armed, a write with any other key leaves the count unchanged, and the watchdog cannot be stopped by software.
- R8: While the block is armed, the second selected tick after arming or the last restart causes `wdt_rst` to be high for exactly one cycle, in the cycle after the clock edge that samples that tick.
- R9: At the moment the reset pulse is issued the block becomes unarmed. Further ticks then produce no reset until a new arming write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Control register write strobe |
| wr_key | input | 4 | Key field of the written value |
| wr_src | input | 1 | Tick source select in the written value (0 main, 1 sub) |
| tick_main | input | 1 | One-cycle tick strobe from the main-clock timebase |
| tick_sub | input | 1 | One-cycle tick strobe from the subclock prescaler |
| wdt_rst | output | 1 | One-cycle watchdog reset pulse |

## Verification
The assertions assume that the tick inputs and the write strobe are synchronous to `clk` and that each is valid for one cycle at a time. They also assume that the internal reset has been released before any write arrives. The stimulus drives every input on the falling edge. It holds all inputs idle through reset and through the two synchronizer cycles that follow. Each strobe is random per cycle, so the two ticks, a write, a restart and a final tick can fall in the same cycle, and those overlaps are part of the expected behaviour.

// File: rtl/wdt_keyed_pkg.sv
package wdt_keyed_pkg;
  typedef enum logic {
    WD_IDLE  = 1'b0,
    WD_ARMED = 1'b1
  } wd_state_e;

  typedef enum logic {
    SRC_MAIN = 1'b0,
    SRC_SUB  = 1'b1
  } wd_src_e;
endpackage

// File: rtl/wdt_rst_sync.sv
module wdt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/wdt_key_dec.sv
module wdt_key_dec #(
  parameter int               KEY_W   = 4,
  parameter logic [KEY_W-1:0] KEY_VAL = 4'b0101
) (
  input  logic             wr_en,
  input  logic [KEY_W-1:0] wr_key,
  input  logic             armed,
  output logic             start_req,
  output logic             clear_req
);
  logic key_hit;

  always_comb begin
    key_hit   = wr_en && (wr_key == KEY_VAL);
    start_req = key_hit && !armed;
    clear_req = key_hit &&  armed;
  end
endmodule

// File: rtl/wdt_src_sel.sv
module wdt_src_sel
  import wdt_keyed_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    load,
  input  logic    src_in,
  input  logic    tick_main,
  input  logic    tick_sub,
  output wd_src_e src_q,
  output logic    sel_tick
);
  wd_src_e src_d;

  always_comb begin
    src_d = src_q;
    if (load) src_d = wd_src_e'(src_in);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    src_q <= SRC_MAIN;
    else if (load) src_q <= src_d;
  end

  always_comb begin
    sel_tick = (src_q == SRC_SUB) ? tick_sub : tick_main;
  end
endmodule

// File: rtl/wdt_tick_cnt.sv
module wdt_tick_cnt #(
  parameter int TIMEOUT_TICKS = 2,
  localparam int CNT_W = $clog2(TIMEOUT_TICKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_TICKS - 1);

  logic [CNT_W-1:0] cnt_d;
  logic             cnt_we;

  always_comb begin
    expire = en && !clr && (cnt == LAST);
    cnt_we = clr || en;
    cnt_d  = cnt;
    if (clr || expire) cnt_d = '0;
    else if (en)       cnt_d = cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_we) cnt <= cnt_d;
  end
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
  import wdt_keyed_pkg::*;
#(
  parameter int               KEY_W         = 4,
  parameter logic [KEY_W-1:0] KEY_VAL       = 4'b0101,
  parameter int               TIMEOUT_TICKS = 2,
  parameter int               SYNC_STAGES   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [KEY_W-1:0] wr_key,
  input  logic             wr_src,
  input  logic             tick_main,
  input  logic             tick_sub,
  output logic             wdt_rst
);
  localparam int CNT_W = $clog2(TIMEOUT_TICKS + 1);

  logic             rst_sync_n;
  wd_state_e        state_q, state_d;
  logic             armed;
  logic             start_req, clear_req;
  wd_src_e          src_q;
  logic             sel_tick;
  logic [CNT_W-1:0] cnt;
  logic             expire;
  logic             rst_q;

  wdt_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign armed = (state_q == WD_ARMED);

  wdt_key_dec #(.KEY_W(KEY_W), .KEY_VAL(KEY_VAL)) u_dec (
    .wr_en     (wr_en),
    .wr_key    (wr_key),
    .armed     (armed),
    .start_req (start_req),
    .clear_req (clear_req)
  );

  wdt_src_sel u_src (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load      (start_req),
    .src_in    (wr_src),
    .tick_main (tick_main),
    .tick_sub  (tick_sub),
    .src_q     (src_q),
    .sel_tick  (sel_tick)
  );

  wdt_tick_cnt #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .clr    (start_req || clear_req),
    .en     (armed && sel_tick),
    .cnt    (cnt),
    .expire (expire)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      WD_IDLE:  if (start_req) state_d = WD_ARMED;
      WD_ARMED: if (expire)    state_d = WD_IDLE;
      default:                 state_d = WD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= WD_IDLE;
      rst_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      rst_q   <= expire;
    end
  end

  assign wdt_rst = rst_q;
endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk #(
  parameter int               KEY_W   = 4,
  parameter logic [KEY_W-1:0] KEY_VAL = 4'b0101,
  parameter int               CNT_W   = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [KEY_W-1:0] wr_key,
  input logic             armed,
  input logic             src_bit,
  input logic             sel_tick,
  input logic [CNT_W-1:0] cnt,
  input logic             wdt_rst
);
  // R1
  idle_in_reset_chk: assert property (@(posedge clk) !rst_n |=> !wdt_rst);

  // R2
  arm_on_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && wr_en && wr_key == KEY_VAL) |=> (armed && cnt == '0));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !(wr_en && wr_key == KEY_VAL)) |=> (!armed && !wdt_rst));

  // R5
  src_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(armed)) |-> $stable(src_bit));

  // R6
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && wr_en && wr_key == KEY_VAL) |=> (cnt == '0 && !wdt_rst));

  // R8
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |=> !wdt_rst);

  // R8
  pulse_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |-> $past(armed && sel_tick));

  // R9
  disarm_on_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |-> !armed);
endmodule

bind wdt_keyed wdt_keyed_chk #(
  .KEY_W   (KEY_W),
  .KEY_VAL (KEY_VAL),
  .CNT_W   (CNT_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .wr_en    (wr_en),
  .wr_key   (wr_key),
  .armed    (armed),
  .src_bit  (src_q),
  .sel_tick (sel_tick),
  .cnt      (cnt),
  .wdt_rst  (wdt_rst)
);

// File: tb/wdt_keyed_tb.sv
module wdt_keyed_tb;
  localparam logic [3:0] KEY = 4'b0101;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, wr_src, tick_main, tick_sub;
  logic [3:0] wr_key;
  logic       wdt_rst;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  bit m_armed = 0;
  bit m_src   = 0;
  int m_cnt   = 0;

  always #4 clk = ~clk;

  wdt_keyed u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_key(wr_key),
    .wr_src(wr_src), .tick_main(tick_main), .tick_sub(tick_sub),
    .wdt_rst(wdt_rst)
  );

  function automatic bit model_edge(bit we, logic [3:0] k, bit s, bit tm, bit ts);
    bit key_ok = we && (k == KEY);
    bit t;
    if (!m_armed) begin
      if (key_ok) begin m_armed = 1; m_src = s; m_cnt = 0; end
      return 0;
    end
    t = m_src ? ts : tm;
    if (key_ok) begin m_cnt = 0; return 0; end
    if (t) begin
      if (m_cnt == 1) begin m_armed = 0; m_cnt = 0; return 1; end
      m_cnt++;
    end
    return 0;
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: wdt_rst actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(string req, bit we, logic [3:0] k, bit s, bit tm, bit ts);
    bit exp;
    @(negedge clk);
    wr_en = we; wr_key = k; wr_src = s; tick_main = tm; tick_sub = ts;
    @(posedge clk);
    exp = model_edge(we, k, s, tm, ts);
    #2;
    check(req, wdt_rst, exp);
  endtask

  task automatic idle(string req, int n);
    for (int i = 0; i < n; i++) step(req, 0, 4'h0, 0, 0, 0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 0; wr_en = 0; wr_key = 0; wr_src = 0; tick_main = 0; tick_sub = 0;
    repeat (3) @(posedge clk);
    #2 check("R1", wdt_rst, 1'b0);
    @(negedge clk) rst_n = 1;
    idle("R1", 3);

    // R3: wrong keys while unarmed, then ticks on both strobes
    step("R3", 1, 4'b1010, 0, 0, 0);
    step("R3", 1, 4'b0100, 1, 0, 0);
    for (int i = 0; i < 6; i++) step("R3", 0, 0, 0, 1, 1);

    // R2/R4: arm on main with a tick in the same cycle (not counted)
    step("R2", 1, KEY, 0, 1, 0);
    step("R4", 0, 0, 0, 0, 1);      // sub tick ignored
    step("R4", 0, 0, 0, 0, 1);
    step("R8", 0, 0, 0, 1, 0);      // first tick
    step("R7", 1, 4'b1111, 0, 0, 0);// wrong key: no clear
    step("R8", 0, 0, 0, 1, 0);      // second tick -> pulse
    step("R8", 0, 0, 0, 0, 0);      // pulse one cycle only
    // R9: unarmed after pulse
    for (int i = 0; i < 4; i++) step("R9", 0, 0, 0, 1, 1);

    // R4/R5: arm on sub, later write tries main
    step("R4", 1, KEY, 1, 0, 0);
    step("R5", 1, KEY, 0, 0, 1);    // restart, src ignored
    step("R5", 0, 0, 0, 1, 0);      // main ignored
    step("R5", 0, 0, 0, 1, 0);
    step("R6", 0, 0, 0, 0, 1);      // first sub tick
    step("R6", 1, KEY, 0, 0, 1);    // restart wins over tick
    step("R6", 0, 0, 0, 0, 1);      // count 1
    step("R8", 0, 0, 0, 0, 1);      // pulse
    idle("R9", 2);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      bit we = ($urandom % 100) < 12;
      logic [3:0] k = (($urandom % 2) == 0) ? KEY : 4'($urandom);
      step("R8", we, k, 1'($urandom), ($urandom % 100) < 25, ($urandom % 100) < 25);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule